// File: doc/BRIEF.md
# TLB Selective Invalidation Sequencer

This block runs invalidation commands against an array of translation entries that lives outside it. It clears enable bits and writes nothing else. The array has two parts. The first is a set-associative part of `ROWS` rows by `WAYS` ways, where entry number `way*ROWS + row` holds way `way` of row `row`. The second is a fully associative part of `FA_N` entries, numbered after the set-associative part. Once a command is accepted, the sequencer presents one entry number per cycle on `entry_idx`. It reads that entry's fields back in the same cycle and raises `clr_we` when the entry must be disabled. The array drops the enable bit of `entry_idx` at the clock edge that ends that cycle.

Seven opcodes are supported. Five of them walk the whole array, selecting entries by the global bit, by an address-space identifier, or by a page match combined with either of those. Two are driven by an index: they touch either one row of the set-associative part or every fully associative entry, and they clear either the non-global entries of the current address space or every selected entry. The page compare ignores the page-offset bits plus the bit that selects one page of an even/odd pair. Set-associative entries use a shared page size for this compare. Fully associative entries use the page size stored in each entry.

Top module: `tlb_inv_seq`

## Requirements
- R1: After reset `busy`, `done` and `clr_we` are low, and `clr_we` stays low whenever `busy` is low.
- R2: Opcode 0 (clear all) disables every entry in the array.
- R3: Opcode 1 (global select) disables exactly the entries whose global bit equals `cmd_gsel`.
- R4: Opcode 2 (space clear) disables the non-global entries whose identifier equals `cmd_info[9:0]`. Bits 31:10 of `cmd_info` have no effect.
- R5: Opcode 3 (page in space) disables enabled entries that are non-global, whose identifier equals `cmd_info[9:0]`, and whose page matches `cmd_va`.
- R6: Opcode 4 (page in space or global) disables enabled entries that are global or whose identifier equals `cmd_info[9:0]`, provided the page also matches `cmd_va`.
- R7: A page matches when `cmd_va >> (ps+1)` equals `{ent_vppn,13'b0} >> (ps+1)`. `ent_vppn` holds address bits 47:13. `ps` is `shared_ps` for entries below `ROWS*WAYS` and `ent_ps` for the others.
- R8: Opcode 5 (row clear) uses `cmd_index`. An index below `ROWS*WAYS` selects entries `w*ROWS + (cmd_index mod ROWS)` for every way `w`, visited with a stride of `ROWS`. An index below the total entry count selects all fully associative entries. Selected entries that are non-global and whose identifier equals `cur_asid` are disabled.
- R9: Opcode 6 (row flush) selects entries the same way as R8 and disables every selected entry.
- R10: A row command whose index is at or beyond the total entry count, and opcode 7, change no entry. For these, `done` is high in the cycle after the accepting edge and `busy` stays low.
- R11: A walk over L entries raises `done` for one cycle at the L-th clock edge after the accepting edge. A command presented while `busy` is high is ignored.
- R12: `clr_we` is raised only for an entry whose enable bit reads as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 3 | Opcode 0..7 |
| cmd_gsel | input | 1 | Global value for opcode 1 |
| cmd_info | input | 32 | Information operand, identifier in bits 9:0 |
| cmd_va | input | VA_W | Virtual address for page compares |
| cmd_index | input | IDX_W+1 | Entry index for opcodes 5 and 6 |
| cur_asid | input | 10 | Current address-space identifier for opcode 5 |
| shared_ps | input | 6 | Page size of the set-associative part |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| entry_idx | output | IDX_W | Entry number being examined |
| ent_en | input | 1 | Enable bit of the examined entry |
| ent_g | input | 1 | Global bit of the examined entry |
| ent_asid | input | 10 | Identifier of the examined entry |
| ent_vppn | input | VA_W-13 | Page-pair number (address bits VA_W-1:13) |
| ent_ps | input | 6 | Stored page size (used for the associative part) |
| clr_we | output | 1 | Disable `entry_idx` at the coming edge |

## Verification
The assertions take for granted that the array returns the fields of `entry_idx` in the same cycle, and that it drops only that entry's enable bit when `clr_we` is high. They also take for granted that every page size presented is at least 12. The bench keeps to these assumptions in two ways. Its array model answers reads combinationally and applies clears only at clock edges. Its random fills and shared page sizes draw only from sizes 12, 14, 16 and 21. Inputs change on falling edges, and commands are held for one cycle only.

// File: rtl/tlb_inv_pkg.sv
package tlb_inv_pkg;
  localparam int ASID_W   = 10;
  localparam int PS_W     = 6;
  localparam int VPPN_LSB = 13;

  typedef enum logic [2:0] {
    OP_ALL       = 3'd0,
    OP_GSEL      = 3'd1,
    OP_ASID      = 3'd2,
    OP_PG_ASID   = 3'd3,
    OP_PG_ASID_G = 3'd4,
    OP_ROW_CLR   = 3'd5,
    OP_ROW_FLUSH = 3'd6,
    OP_NONE      = 3'd7
  } inv_op_e;

  typedef enum logic [1:0] {
    WALK_ALL = 2'd0,
    WALK_ROW = 2'd1,
    WALK_FA  = 2'd2
  } walk_e;
endpackage

// File: rtl/tlb_inv_decode.sv
module tlb_inv_decode
  import tlb_inv_pkg::*;
#(
  parameter int ROWS  = 256,
  parameter int WAYS  = 8,
  parameter int FA_N  = 64,
  parameter int IDX_W = 12
) (
  input  inv_op_e          op,
  input  logic [IDX_W:0]   index,
  output walk_e            mode,
  output logic [IDX_W-1:0] last,
  output logic             noop
);
  localparam int SA_N  = ROWS * WAYS;
  localparam int TOTAL = SA_N + FA_N;
  localparam logic [IDX_W:0]   SA_I    = (IDX_W+1)'(SA_N);
  localparam logic [IDX_W:0]   TOTAL_I = (IDX_W+1)'(TOTAL);
  localparam logic [IDX_W-1:0] LAST_ALL = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(WAYS - 1);
  localparam logic [IDX_W-1:0] LAST_FA  = IDX_W'(FA_N - 1);

  always_comb begin
    mode = WALK_ALL;
    last = LAST_ALL;
    noop = 1'b0;
    case (op)
      OP_ROW_CLR, OP_ROW_FLUSH: begin
        if (index < SA_I) begin
          mode = WALK_ROW;
          last = LAST_ROW;
        end else if (index < TOTAL_I) begin
          mode = WALK_FA;
          last = LAST_FA;
        end else begin
          noop = 1'b1;
        end
      end
      OP_NONE: noop = 1'b1;
      default: begin
        mode = WALK_ALL;
        last = LAST_ALL;
      end
    endcase
  end
endmodule

// File: rtl/tlb_inv_walk.sv
module tlb_inv_walk
  import tlb_inv_pkg::*;
#(
  parameter int ROWS  = 256,
  parameter int WAYS  = 8,
  parameter int IDX_W = 12,
  parameter int ROW_W = 8
) (
  input  walk_e            mode,
  input  logic [ROW_W-1:0] row,
  input  logic [IDX_W-1:0] cnt,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] ROWS_I = IDX_W'(ROWS);
  localparam logic [IDX_W-1:0] SA_I   = IDX_W'(ROWS * WAYS);

  // Way-major numbering: way w of row r is entry w*ROWS + r.
  function automatic logic [IDX_W-1:0] row_member(input logic [IDX_W-1:0] way,
                                                  input logic [ROW_W-1:0] r);
    return way * ROWS_I + IDX_W'(r);
  endfunction

  always_comb begin
    case (mode)
      WALK_ROW: idx = row_member(cnt, row);
      WALK_FA:  idx = SA_I + cnt;
      default:  idx = cnt;
    endcase
  end
endmodule

// File: rtl/tlb_inv_match.sv
module tlb_inv_match
  import tlb_inv_pkg::*;
#(
  parameter int VA_W  = 48,
  parameter int SA_N  = 2048,
  parameter int IDX_W = 12
) (
  input  inv_op_e                    op,
  input  logic [ASID_W-1:0]          asid,
  input  logic                       gsel,
  input  logic [VA_W-1:0]            va,
  input  logic [PS_W-1:0]            shared_ps,
  input  logic [IDX_W-1:0]           entry_idx,
  input  logic                       ent_en,
  input  logic                       ent_g,
  input  logic [ASID_W-1:0]          ent_asid,
  input  logic [VA_W-VPPN_LSB-1:0]   ent_vppn,
  input  logic [PS_W-1:0]            ent_ps,
  output logic                       hit
);
  localparam logic [IDX_W-1:0] SA_I = IDX_W'(SA_N);

  // Bits above ps+1 must agree; the pair-select bit and the offset are ignored.
  function automatic logic page_hit(input logic [VA_W-1:0] a,
                                    input logic [VA_W-VPPN_LSB-1:0] vppn,
                                    input logic [PS_W-1:0] ps);
    logic [VA_W-1:0] ent_va;
    logic [VA_W-1:0] keep;
    ent_va = {vppn, {VPPN_LSB{1'b0}}};
    keep   = {VA_W{1'b1}} << ({1'b0, ps} + 7'd1);
    return ((a ^ ent_va) & keep) == '0;
  endfunction

  logic [PS_W-1:0] eff_ps;
  logic            asid_eq;
  logic            pg_eq;

  assign eff_ps  = (entry_idx < SA_I) ? shared_ps : ent_ps;
  assign asid_eq = (ent_asid == asid);
  assign pg_eq   = page_hit(va, ent_vppn, eff_ps);

  always_comb begin
    case (op)
      OP_ALL:       hit = ent_en;
      OP_GSEL:      hit = ent_en && (ent_g == gsel);
      OP_ASID:      hit = ent_en && !ent_g && asid_eq;
      OP_PG_ASID:   hit = ent_en && !ent_g && asid_eq && pg_eq;
      OP_PG_ASID_G: hit = ent_en && (ent_g || asid_eq) && pg_eq;
      OP_ROW_CLR:   hit = ent_en && !ent_g && asid_eq;
      OP_ROW_FLUSH: hit = ent_en;
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_inv_seq.sv
module tlb_inv_seq
  import tlb_inv_pkg::*;
#(
  parameter  int ROWS   = 256,
  parameter  int WAYS   = 8,
  parameter  int FA_N   = 64,
  parameter  int VA_W   = 48,
  localparam int SA_N   = ROWS * WAYS,
  localparam int TOTAL  = SA_N + FA_N,
  localparam int IDX_W  = $clog2(TOTAL),
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int VPPN_W = VA_W - VPPN_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic               cmd_gsel,
  input  logic [31:0]        cmd_info,
  input  logic [VA_W-1:0]    cmd_va,
  input  logic [IDX_W:0]     cmd_index,
  input  logic [ASID_W-1:0]  cur_asid,
  input  logic [PS_W-1:0]    shared_ps,
  output logic               busy,
  output logic               done,
  output logic [IDX_W-1:0]   entry_idx,
  input  logic               ent_en,
  input  logic               ent_g,
  input  logic [ASID_W-1:0]  ent_asid,
  input  logic [VPPN_W-1:0]  ent_vppn,
  input  logic [PS_W-1:0]    ent_ps,
  output logic               clr_we
);
  inv_op_e           op_in;
  walk_e             dec_mode;
  logic [IDX_W-1:0]  dec_last;
  logic              dec_noop;

  logic              busy_q, done_q, gsel_q;
  inv_op_e           op_q;
  walk_e             mode_q;
  logic [ASID_W-1:0] asid_q;
  logic [VA_W-1:0]   va_q;
  logic [PS_W-1:0]   sps_q;
  logic [ROW_W-1:0]  row_q;
  logic [IDX_W-1:0]  cnt_q, last_q;

  // Named events for the checker.
  logic cmd_accept, accept_noop, walk_end, walk_row, hit;
  logic unused_info;

  assign op_in       = inv_op_e'(cmd_op);
  assign cmd_accept  = cmd_valid && !busy_q;
  assign accept_noop = cmd_accept && dec_noop;
  assign walk_end    = busy_q && (cnt_q == last_q);
  assign walk_row    = busy_q && (mode_q == WALK_ROW);
  assign unused_info = ^cmd_info[31:ASID_W];

  tlb_inv_decode #(.ROWS(ROWS), .WAYS(WAYS), .FA_N(FA_N), .IDX_W(IDX_W)) u_dec (
    .op(op_in), .index(cmd_index), .mode(dec_mode), .last(dec_last), .noop(dec_noop)
  );

  tlb_inv_walk #(.ROWS(ROWS), .WAYS(WAYS), .IDX_W(IDX_W), .ROW_W(ROW_W)) u_walk (
    .mode(mode_q), .row(row_q), .cnt(cnt_q), .idx(entry_idx)
  );

  tlb_inv_match #(.VA_W(VA_W), .SA_N(SA_N), .IDX_W(IDX_W)) u_match (
    .op(op_q), .asid(asid_q), .gsel(gsel_q), .va(va_q), .shared_ps(sps_q),
    .entry_idx(entry_idx), .ent_en(ent_en), .ent_g(ent_g), .ent_asid(ent_asid),
    .ent_vppn(ent_vppn), .ent_ps(ent_ps), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      gsel_q <= 1'b0;
      op_q   <= OP_NONE;
      mode_q <= WALK_ALL;
      asid_q <= '0;
      va_q   <= '0;
      sps_q  <= '0;
      row_q  <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (cmd_accept) begin
        op_q   <= op_in;
        mode_q <= dec_mode;
        last_q <= dec_last;
        cnt_q  <= '0;
        gsel_q <= cmd_gsel;
        va_q   <= cmd_va;
        sps_q  <= shared_ps;
        row_q  <= ROW_W'(cmd_index % (IDX_W+1)'(ROWS));
        asid_q <= (op_in == OP_ROW_CLR) ? cur_asid : cmd_info[ASID_W-1:0];
        busy_q <= !dec_noop;
        done_q <= dec_noop;
      end else if (busy_q) begin
        if (walk_end) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign clr_we = busy_q && hit;
endmodule

// File: rtl/tlb_inv_seq_chk.sv
module tlb_inv_seq_chk
  import tlb_inv_pkg::*;
#(
  parameter int ROWS  = 256,
  parameter int IDX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             clr_we,
  input logic             ent_en,
  input logic             ent_g,
  input logic             gsel_q,
  input inv_op_e          op_q,
  input logic             accept_noop,
  input logic             walk_row,
  input logic [IDX_W-1:0] entry_idx
);
  localparam logic [IDX_W-1:0] ROWS_I = IDX_W'(ROWS);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !clr_we);

  p_we_enabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |-> ent_en);

  p_gsel_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && op_q == OP_GSEL) |-> (ent_g == gsel_q));

  // R4, R5 and R8 all spare global entries.
  p_global_spared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (op_q == OP_ASID || op_q == OP_PG_ASID || op_q == OP_ROW_CLR)) |-> !ent_g);

  p_row_stride_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_row && $past(walk_row) && $past(busy)) |-> (entry_idx - $past(entry_idx) == ROWS_I));

  p_noop_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_noop |=> (done && !busy));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind tlb_inv_seq tlb_inv_seq_chk #(.ROWS(ROWS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .clr_we(clr_we),
  .ent_en(ent_en), .ent_g(ent_g), .gsel_q(gsel_q), .op_q(op_q),
  .accept_noop(accept_noop), .walk_row(walk_row), .entry_idx(entry_idx)
);

// File: tb/tlb_inv_seq_tb.sv
module tlb_inv_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 16;
  localparam int WAYS  = 4;
  localparam int FA_N  = 8;
  localparam int VA_W  = 48;
  localparam int SA_N  = ROWS * WAYS;
  localparam int TOTAL = SA_N + FA_N;
  localparam int IDX_W = $clog2(TOTAL);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_gsel = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [31:0] cmd_info = '0;
  logic [VA_W-1:0] cmd_va = '0;
  logic [IDX_W:0] cmd_index = '0;
  logic [9:0] cur_asid = '0;
  logic [5:0] shared_ps = 6'd14;
  logic busy, done, clr_we;
  logic [IDX_W-1:0] entry_idx;
  logic ent_en, ent_g;
  logic [9:0] ent_asid;
  logic [VA_W-14:0] ent_vppn;
  logic [5:0] ent_ps;

  logic            arr_en   [TOTAL];
  logic            arr_g    [TOTAL];
  logic [9:0]      arr_asid [TOTAL];
  logic [VA_W-14:0] arr_vppn [TOTAL];
  logic [5:0]      arr_ps   [TOTAL];
  bit              exp_en   [TOTAL];
  logic refill = 1'b0;

  int vectors = 0, miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_inv_seq #(.ROWS(ROWS), .WAYS(WAYS), .FA_N(FA_N), .VA_W(VA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_gsel(cmd_gsel), .cmd_info(cmd_info), .cmd_va(cmd_va),
    .cmd_index(cmd_index), .cur_asid(cur_asid), .shared_ps(shared_ps),
    .busy(busy), .done(done), .entry_idx(entry_idx), .ent_en(ent_en),
    .ent_g(ent_g), .ent_asid(ent_asid), .ent_vppn(ent_vppn), .ent_ps(ent_ps),
    .clr_we(clr_we)
  );

  // Array model: combinational read, clear at the edge.
  assign ent_en   = arr_en[entry_idx];
  assign ent_g    = arr_g[entry_idx];
  assign ent_asid = arr_asid[entry_idx];
  assign ent_vppn = arr_vppn[entry_idx];
  assign ent_ps   = arr_ps[entry_idx];

  function automatic logic [5:0] pick_ps(int k);
    case (k % 4)
      0: return 6'd12;
      1: return 6'd14;
      2: return 6'd16;
      default: return 6'd21;
    endcase
  endfunction

  always @(posedge clk) begin
    if (refill) begin
      for (int i = 0; i < TOTAL; i++) begin
        arr_en[i]   <= ($urandom % 4) != 0;
        arr_g[i]    <= ($urandom % 4) == 0;
        arr_asid[i] <= 10'(1 + $urandom % 3);
        arr_vppn[i] <= 35'((($urandom % 4) << 9) | ($urandom % 4));
        arr_ps[i]   <= pick_ps($urandom);
      end
    end else if (clr_we) begin
      arr_en[entry_idx] <= 1'b0;
    end
  end

  function automatic bit pg_match(logic [VA_W-1:0] va, logic [VA_W-14:0] vppn, int ps);
    logic [VA_W-1:0] wide;
    wide = {13'b0, vppn};
    return (va >> (ps + 1)) == (wide >> (ps + 1 - 13));
  endfunction

  function automatic string op_tag(int op);
    case (op)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R8"; 6: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic do_refill();
    @(negedge clk); refill = 1'b1;
    @(negedge clk); refill = 1'b0;
  endtask

  // Compute expected enables and walk length, apply, then compare.
  task automatic run_cmd(int op, bit gs, logic [31:0] info, logic [VA_W-1:0] va,
                         int index, logic [9:0] casid, logic [5:0] sps, string tag);
    int len, n, first_bad;
    bit sel, clr, ok;
    logic [9:0] a;
    len = 0;
    a = (op == 5) ? casid : info[9:0];
    if (op <= 4) len = TOTAL;
    else if (op <= 6 && index < SA_N) len = WAYS;
    else if (op <= 6 && index < TOTAL) len = FA_N;
    for (int i = 0; i < TOTAL; i++) begin
      int ps;
      ps = (i < SA_N) ? int'(sps) : int'(arr_ps[i]);
      if (op == 5 || op == 6)
        sel = (index < SA_N) ? (i < SA_N && (i % ROWS) == (index % ROWS))
                             : (index < TOTAL && i >= SA_N);
      else sel = 1'b1;
      case (op)
        0: clr = 1'b1;
        1: clr = (arr_g[i] == gs);
        2: clr = !arr_g[i] && arr_asid[i] == a;
        3: clr = !arr_g[i] && arr_asid[i] == a && pg_match(va, arr_vppn[i], ps);
        4: clr = (arr_g[i] || arr_asid[i] == a) && pg_match(va, arr_vppn[i], ps);
        5: clr = sel && !arr_g[i] && arr_asid[i] == a;
        6: clr = sel;
        default: clr = 1'b0;
      endcase
      exp_en[i] = arr_en[i] && !clr;
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_gsel = gs; cmd_info = info;
    cmd_va = va; cmd_index = (IDX_W+1)'(index); cur_asid = casid; shared_ps = sps;
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      cmd_valid = 1'b0;
      n++;
    end while (!done && n < 1000);
    vectors++;
    if (n != len + 1) begin
      miscompares++;
      $display("FAIL R11 (%s) done latency: got %0d expected %0d", tag, n, len + 1);
    end
    ok = 1'b1; first_bad = -1;
    for (int i = 0; i < TOTAL; i++)
      if (arr_en[i] != exp_en[i] && ok) begin ok = 1'b0; first_bad = i; end
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s entry %0d enable: got %0b expected %0b", tag, first_bad,
               arr_en[first_bad], exp_en[first_bad]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    vectors++;
    if (busy !== 1'b0 || done !== 1'b0 || clr_we !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset outputs: got %b%b%b expected 000", busy, done, clr_we);
    end
    rst_n = 1'b1;

    do_refill(); run_cmd(0, 0, 32'd0, '0, 0, 10'd0, 6'd14, "R2");
    do_refill(); run_cmd(1, 1, 32'd0, '0, 0, 10'd0, 6'd14, "R3");
    do_refill(); run_cmd(1, 0, 32'd0, '0, 0, 10'd0, 6'd14, "R3");
    do_refill(); run_cmd(2, 0, 32'hABCD_FC02, '0, 0, 10'd0, 6'd14, "R4");
    do_refill(); run_cmd(3, 0, 32'd1, {arr_vppn[SA_N+1], 13'h1ABC}, 0, 10'd0, 6'd12, "R5/R7");
    do_refill(); run_cmd(4, 0, 32'd2, {arr_vppn[3], 13'h0F00}, 0, 10'd0, 6'd16, "R6/R7");
    do_refill(); run_cmd(4, 0, 32'd3, {arr_vppn[SA_N+5], 13'h0}, 0, 10'd0, 6'd21, "R6/R7");
    do_refill(); run_cmd(5, 0, 32'd0, '0, ROWS*2 + 5, 10'd2, 6'd14, "R8");
    do_refill(); run_cmd(5, 0, 32'd0, '0, SA_N + 3, 10'd1, 6'd14, "R8");
    do_refill(); run_cmd(6, 0, 32'd0, '0, ROWS - 1, 10'd0, 6'd14, "R9");
    do_refill(); run_cmd(6, 0, 32'd0, '0, TOTAL - 1, 10'd0, 6'd14, "R9");
    do_refill(); run_cmd(6, 0, 32'd0, '0, TOTAL, 10'd0, 6'd14, "R10");
    do_refill(); run_cmd(5, 0, 32'd0, '0, 2*TOTAL - 1, 10'd1, 6'd14, "R10");
    do_refill(); run_cmd(7, 0, 32'd0, '0, 0, 10'd0, 6'd14, "R10");

    // R11: a clear-all presented mid-walk must be ignored.
    do_refill();
    begin
      bit ok;
      for (int i = 0; i < TOTAL; i++) exp_en[i] = arr_en[i] && (i < SA_N);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd6; cmd_index = (IDX_W+1)'(SA_N);
      @(negedge clk);
      cmd_op = 3'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!done) @(negedge clk);
      ok = 1'b1;
      for (int i = 0; i < TOTAL; i++) if (arr_en[i] != exp_en[i]) ok = 1'b0;
      vectors++;
      if (!ok) begin
        miscompares++;
        $display("FAIL R11 busy-ignore: got altered array expected FA-only flush");
      end
    end

    for (int t = 0; t < 60; t++) begin
      int op, j;
      do_refill();
      op = $urandom % 8;
      j = $urandom % TOTAL;
      run_cmd(op, 1'($urandom), 32'(($urandom & 32'hFFFF_FC00) | (1 + $urandom % 3)),
              {arr_vppn[j], 13'h0} ^ 48'($urandom % 32768),
              $urandom % (TOTAL + 8), 10'(1 + $urandom % 3),
              pick_ps($urandom), op_tag(op));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule